// File: doc/BRIEF.md
# Two-Tap Pre-FFT Spectral Shaping Filter

This block is a streaming two-tap FIR stage placed directly ahead of the range FFT in a linear-FM continuous-wave radar receiver. It takes complex baseband samples, with the in-phase and quadrature parts carried on separate signed fixed-point inputs. Each sample comes with a valid flag and a start-of-ramp marker. For every valid sample it produces y(n) = x(n) − 0.5·x(n−1), which is the transfer function H(z) = 1 − 0.5·z⁻¹. The output carries a valid flag and a marker that are delayed to match the data.

The weight of 1 applies to the current sample and the weight of −0.5 applies to the previous one. The half-weight tap is an arithmetic right shift by one bit of the stored sample, so no multiplier is needed. The output is one bit wider than the input, so no result can overflow and none is saturated. A single one-sample delay register per lane holds the history. That history is treated as zero on the first sample of every ramp, so one ramp of range samples (typically 1,024) never leaks into the next.

Top module: `ramp_tap_shaper`

## Requirements
- R1: For a valid sample that is not marked start-of-ramp, each lane outputs x − (p >>> 1) as a DW+1 bit two's complement value. Here p is the last valid sample of that lane and >>> 1 is an arithmetic shift, which is floor division by two (for example p = −3 gives −2).
- R2: For a valid sample with the start-of-ramp marker high, the previous sample is taken as zero, so the output equals x sign-extended to DW+1 bits. That sample then becomes the history for the next one.
- R3: The output width is DW+1 bits and is never saturated. With DW=16, x = −32768 after p = 32767 gives −49151, and x = 32767 after p = −32768 gives 49151.
- R4: The output for a valid input sample appears exactly one clock later, with out_vld high in that cycle. out_vld is low in the cycle after any cycle in which in_vld was low.
- R5: out_sor is high exactly one clock after a cycle in which in_vld and in_sor were both high, and low otherwise. A marker that arrives with in_vld low is ignored: it does not reach out_sor and it does not clear the history.
- R6: Cycles with in_vld low do not change the history register, whatever data is on the inputs.
- R7: When out_vld is low, out_i and out_q keep the value they had in the previous cycle.
- R8: While rst_n is low, out_vld, out_sor, out_i and out_q are all zero and the history is zero. The first valid sample after reset without a marker therefore outputs x unchanged. Reset is asserted asynchronously and released synchronously two clocks after rst_n rises.
- R9: The I and Q lanes are independent: data on one lane never affects the other lane's output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_vld | input | 1 | Input sample valid |
| in_sor | input | 1 | First sample of a ramp; only acts when in_vld is high |
| in_i | input | DW | In-phase sample, signed |
| in_q | input | DW | Quadrature sample, signed |
| out_vld | output | 1 | Output sample valid, one cycle after in_vld |
| out_sor | output | 1 | Delayed start-of-ramp marker |
| out_i | output | DW+1 | Filtered in-phase sample, signed |
| out_q | output | DW+1 | Filtered quadrature sample, signed |

## Verification
The bench runs a marked ramp of mixed positive and negative samples, including odd negative history values, to separate an arithmetic shift from a logical shift or a truncation toward zero. Back-to-back ramps show that the marker clears the history, and a marker sent with valid low shows that it is ignored. Gaps with changing junk data on the inputs show that the history register and the held outputs are not disturbed. Full-scale samples of alternating sign test the widened output, and opposite patterns on I and Q show that the two lanes do not cross.

// File: rtl/ramp_tap_pkg.sv
package ramp_tap_pkg;
  // Number of parallel data lanes (in-phase and quadrature).
  localparam int NUM_LANES = 2;

  // Lane indices used to map the ports onto the lane array.
  typedef enum int {
    LANE_I = 0,
    LANE_Q = 1
  } lane_e;

  // Depth of the internal reset release synchronizer.
  localparam int RST_STAGES = 2;
endpackage

// File: rtl/ramp_tap_rst_sync.sv
// Asynchronous assert, synchronous release of the active-low reset.
module ramp_tap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/ramp_tap_hist.sv
// One-sample delay register of a lane. It only loads on valid samples.
module ramp_tap_hist #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic signed [DW-1:0] smp,
  output logic signed [DW-1:0] hist
);
  logic signed [DW-1:0] hist_q;
  logic signed [DW-1:0] hist_d;

  always_comb begin
    hist_d = hist_q;
    if (load_en) hist_d = smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist = hist_q;
endmodule

// File: rtl/ramp_tap_sub.sv
// Combinational tap sum: current sample minus half of the previous one.
// The half weight is a one-bit arithmetic shift; a ramp restart zeroes the
// previous-sample term.
module ramp_tap_sub #(
  parameter int DW = 16
) (
  input  logic                 restart,
  input  logic signed [DW-1:0] cur,
  input  logic signed [DW-1:0] prev,
  output logic signed [DW:0]   diff
);
  localparam int OW = DW + 1;

  logic signed [DW-1:0] prev_eff;
  logic signed [DW-1:0] prev_half;
  logic signed [OW-1:0] cur_ext;
  logic signed [OW-1:0] half_ext;

  always_comb begin
    prev_eff  = restart ? '0 : prev;
    prev_half = prev_eff >>> 1;
    cur_ext   = {cur[DW-1], cur};
    half_ext  = {prev_half[DW-1], prev_half};
    diff      = cur_ext - half_ext;
  end
endmodule

// File: rtl/ramp_tap_lane.sv
// One data lane: history register, tap arithmetic and output register.
module ramp_tap_lane #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 smp_en,
  input  logic                 restart,
  input  logic signed [DW-1:0] x,
  output logic signed [DW:0]   y
);
  localparam int OW = DW + 1;

  logic signed [DW-1:0] hist;
  logic signed [OW-1:0] diff;
  logic signed [OW-1:0] y_q;
  logic signed [OW-1:0] y_d;

  ramp_tap_hist #(.DW(DW)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_en (smp_en),
    .smp     (x),
    .hist    (hist)
  );

  ramp_tap_sub #(.DW(DW)) u_sub (
    .restart (restart),
    .cur     (x),
    .prev    (hist),
    .diff    (diff)
  );

  // The output register only loads on valid samples, otherwise it holds.
  always_comb begin
    y_d = y_q;
    if (smp_en) y_d = diff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) y_q <= '0;
    else        y_q <= y_d;
  end

  assign y = y_q;
endmodule

// File: rtl/ramp_tap_ctrl.sv
// Valid and start-of-ramp side-band pipeline. It is aligned to the lane
// output register.
module ramp_tap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_vld,
  input  logic in_sor,
  output logic smp_en,
  output logic restart,
  output logic out_vld,
  output logic out_sor
);
  logic vld_q, vld_d;
  logic sor_q, sor_d;

  always_comb begin
    smp_en  = in_vld;
    restart = in_vld & in_sor;
    vld_d   = smp_en;
    sor_d   = restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      sor_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      sor_q <= sor_d;
    end
  end

  assign out_vld = vld_q;
  assign out_sor = sor_q;
endmodule

// File: rtl/ramp_tap_shaper.sv
// Top: two-tap 1 / -0.5 shaping filter ahead of the range FFT.
module ramp_tap_shaper #(
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 in_sor,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_vld,
  output logic                 out_sor,
  output logic signed [DW:0]   out_i,
  output logic signed [DW:0]   out_q
);
  import ramp_tap_pkg::*;

  localparam int OW = DW + 1;

  logic rst_sync_n;
  logic smp_en;
  logic restart;

  logic signed [DW-1:0] lane_x [NUM_LANES];
  logic signed [OW-1:0] lane_y [NUM_LANES];

  ramp_tap_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ramp_tap_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .in_vld  (in_vld),
    .in_sor  (in_sor),
    .smp_en  (smp_en),
    .restart (restart),
    .out_vld (out_vld),
    .out_sor (out_sor)
  );

  assign lane_x[int'(LANE_I)] = in_i;
  assign lane_x[int'(LANE_Q)] = in_q;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    ramp_tap_lane #(.DW(DW)) u_lane (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .smp_en  (smp_en),
      .restart (restart),
      .x       (lane_x[g]),
      .y       (lane_y[g])
    );
  end

  assign out_i = lane_y[int'(LANE_I)];
  assign out_q = lane_y[int'(LANE_Q)];
endmodule

// File: rtl/ramp_tap_shaper_chk.sv
// Property checker bound to the top module.
module ramp_tap_shaper_chk #(
  parameter int DW = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic                 in_vld,
  input logic                 in_sor,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_vld,
  input logic                 out_sor,
  input logic signed [DW:0]   out_i,
  input logic signed [DW:0]   out_q
);
  logic armed_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed_q <= 1'b0;
    else             armed_q <= 1'b1;
  end

  // R8
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (!out_vld && !out_sor && out_i == '0 && out_q == '0));

  // R4
  latency_chk: assert property (@(posedge clk) disable iff (!armed_q)
    out_vld == $past(in_vld));

  // R5
  marker_chk: assert property (@(posedge clk) disable iff (!armed_q)
    out_sor == $past(in_vld && in_sor));

  // R2
  restart_i_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (out_vld && out_sor) |-> out_i == {$past(in_i[DW-1]), $past(in_i)});

  // R2
  restart_q_chk: assert property (@(posedge clk) disable iff (!armed_q)
    (out_vld && out_sor) |-> out_q == {$past(in_q[DW-1]), $past(in_q)});

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!armed_q)
    !out_vld |-> ($stable(out_i) && $stable(out_q)));
endmodule

bind ramp_tap_shaper ramp_tap_shaper_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .in_vld     (in_vld),
  .in_sor     (in_sor),
  .in_i       (in_i),
  .in_q       (in_q),
  .out_vld    (out_vld),
  .out_sor    (out_sor),
  .out_i      (out_i),
  .out_q      (out_q)
);

// File: tb/tb_ramp_tap_shaper.sv
`timescale 1ns/1ps
module tb_ramp_tap_shaper;
  localparam int DW = 16;
  localparam int MAXV = (1 << (DW - 1)) - 1;
  localparam int MINV = -(1 << (DW - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic in_sor = 1'b0;
  logic signed [DW-1:0] in_i = '0;
  logic signed [DW-1:0] in_q = '0;
  logic out_vld, out_sor;
  logic signed [DW:0] out_i, out_q;

  int n_chk = 0;
  int n_bad = 0;
  int prev_i = 0, prev_q = 0;
  int hold_i = 0, hold_q = 0;

  always #4 clk = ~clk;  // 125 MHz

  ramp_tap_shaper #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_sor(in_sor),
    .in_i(in_i), .in_q(in_q), .out_vld(out_vld), .out_sor(out_sor),
    .out_i(out_i), .out_q(out_q)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one cycle, then check all outputs against the bench model.
  task automatic apply(input bit v, input bit s, input int xi, input int xq, input string req);
    int ei, eq;
    @(negedge clk);
    in_vld = v; in_sor = s;
    in_i = DW'(xi); in_q = DW'(xq);
    if (v) begin
      ei = xi - (s ? 0 : (prev_i >>> 1));
      eq = xq - (s ? 0 : (prev_q >>> 1));
      prev_i = xi; prev_q = xq;
      hold_i = ei; hold_q = eq;
    end else begin
      ei = hold_i; eq = hold_q;
    end
    @(posedge clk); #1;
    check(req, "out_vld", int'(out_vld), int'(v));
    check(req, "out_sor", int'(out_sor), int'(v & s));
    check(req, "out_i", int'(out_i), ei);
    check(req, "out_q", int'(out_q), eq);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R8", "out_vld in reset", int'(out_vld), 0);
    check("R8", "out_sor in reset", int'(out_sor), 0);
    check("R8", "out_i in reset", int'(out_i), 0);
    check("R8", "out_q in reset", int'(out_q), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    prev_i = 0; prev_q = 0; hold_i = 0; hold_q = 0;
    // first sample without marker: history is zero after reset
    apply(1, 0, 1234, -77, "R8");
  endtask

  task automatic t_ramp;
    apply(1, 1, 100, -100, "R2");
    apply(1, 0, 50, 20, "R1");
    apply(1, 0, -3, 7, "R1");
    apply(1, 0, 10, -5, "R1");    // prev -3 gives -2 (floor)
    apply(1, 0, 0, 0, "R1");      // prev 10 / -5
    apply(1, 0, -1, -1, "R1");
    apply(1, 0, 4, 4, "R4");      // prev -1 gives -1
  endtask

  task automatic t_restart;
    apply(1, 0, 3000, -3000, "R1");
    apply(1, 1, 500, 600, "R2");  // history of previous ramp dropped
    apply(1, 0, 100, 100, "R2");
  endtask

  task automatic t_gaps;
    apply(1, 0, 801, -801, "R6");
    apply(0, 0, 9999, -9999, "R7");
    apply(0, 0, -12345, 222, "R7");
    apply(1, 0, 1, 1, "R6");      // uses 801 / -801
  endtask

  task automatic t_marker_ignored;
    apply(1, 0, 2000, -2000, "R5");
    apply(0, 1, 77, 77, "R5");    // marker without valid
    apply(1, 0, 10, 10, "R5");    // history still 2000 / -2000
  endtask

  task automatic t_extremes;
    apply(1, 1, MAXV, MINV, "R3");
    apply(1, 0, MINV, MAXV, "R3");
    apply(1, 0, MAXV, MINV, "R3");
    apply(1, 0, MINV, MINV, "R3");
  endtask

  task automatic t_lanes;
    apply(1, 1, 0, 0, "R9");
    apply(1, 0, 20000, 0, "R9");
    apply(1, 0, -20000, 0, "R9");
    apply(1, 0, 0, 15000, "R9");
    apply(1, 0, 0, -15000, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ramp();
    t_restart();
    t_gaps();
    t_marker_ignored();
    t_extremes();
    t_lanes();
    apply(0, 0, 0, 0, "R4");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule